// File: doc/BRIEF.md
# Limit-Based Timer/Counter with User Mode

This block is a memory-mapped timer/counter reached through a 32-bit register window of eight word slots, five of them in use. It advances once per tick. A tick comes from a strobe input, optionally divided by an internal prescaler. The count is held in tick units and shown left-justified in register form: it starts at bit `FRAC`, and bits `FRAC-1` down to 0 always read as zero.

In system mode the count wraps at a programmable limit. On each wrap a sticky reached flag and a level interrupt are set. Software acknowledges the event by reading the limit slot. That read also restarts the count. In user mode the same counter becomes a wide free-running counter. Software can stop and restart it and reads it as a high word and a low word. In user mode the interrupt output stays low.

Bus accesses take one cycle. `sel_i` marks an access and `wr_i` selects a write. Read data is combinational from the current state. Read side effects and write effects take hold at the next clock edge.

Top module: `lim_timer`

## Requirements
- R1: The slot is `addr_i` (byte address bits 4:2). Slots 5, 6 and 7 read as zero, and a write to them changes no state.
- R2: Rules for the count and the slot-1 read in system mode:
  - The count advances by one on each tick.
  - A slot-1 read returns the reached flag in bit 31, the low `31-FRAC` count bits at bits 30:`FRAC`, and zero below.
- R3: A write to slot 0 or slot 2 stores `wdata_i[30:0]` as the limit. A write of all-zero data stores 0x7FFFFFFF. A slot-0 write also clears the count, and a slot-2 write leaves the count unchanged.
- R4: Wrap rule in system mode:
  - The period P is the effective limit shifted right by `FRAC`. A stored limit of 0 counts as 0x7FFFFFFF.
  - A tick that finds count+1 >= P sets the count to 0, sets the reached flag and raises `irq_o`.
  - `irq_o` stays high until it is acknowledged.
- R5: In system mode a slot-0 read returns the stored limit. From the next cycle `irq_o` is low, the reached flag is clear and the count is 0.
- R6: A wrap in the same cycle as a slot-0 acknowledging read wins. The reached flag and `irq_o` stay set, and the count is 0.
- R7: In user mode `irq_o` is low. A slot-0 read returns `count >> (31-FRAC)`, masked to 31 bits. A slot-1 read returns the low count bits at bit `FRAC` with bit 31 at zero. Neither read has a side effect.
- R8: Stop and run control:
  - In user mode a write to slot 3 with bit 0 set holds the count.
  - In user mode a write to slot 3 with bit 0 clear resumes counting from the held value.
  - In system mode slot-3 writes are ignored, and the count advances whatever the stop state.
- R9: Slot 3 reads the stop state in bit 0, and slot 4 reads the mode in bit 0 (1 = user, 0 = system). Slot-4 writes set the mode only when `MODE_WR` = 1. Otherwise the mode stays system.
- R10: After reset the limit reads 0, the count is 0, the reached flag and `irq_o` are clear, the stop state is 1 and the mode is system.
- R11: A tick occurs on every `PRESCALE`-th clock in which `tick_i` is high. With `PRESCALE` = 1, each cycle with `tick_i` high is one tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Tick strobe / prescaler enable |
| sel_i | input | 1 | Register access this cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Word slot (byte address bits 4:2) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, zero when no read |
| irq_o | output | 1 | Level interrupt (system mode only) |

## Verification
The wrap event and the acknowledging slot-0 read can land in the same cycle. The read tries to clear the flag and the interrupt while the wrap tries to set them. The bench provokes this by programming a two-tick period, giving one tick, and then issuing the slot-0 read with the tick strobe high. It then checks that `irq_o` and bit 31 of the slot-1 read are still set while the count is 0. Random traffic with frequent ticks and slot-0 reads reproduces the same collision many more times, and a bench model judges each case.

// File: rtl/lim_timer_pkg.sv
package lim_timer_pkg;

    localparam int          LIM_W   = 31;
    localparam logic [30:0] LIM_MAX = 31'h7FFF_FFFF;

    typedef enum logic [2:0] {
        SLOT_LIM_RST  = 3'd0,
        SLOT_COUNT    = 3'd1,
        SLOT_LIM_KEEP = 3'd2,
        SLOT_RUN      = 3'd3,
        SLOT_MODE     = 3'd4
    } slot_e;

endpackage

// File: rtl/lim_timer_tick.sv
module lim_timer_tick #(
    parameter int PRESCALE = 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic tick_o
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    logic [PRE_W-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        if (en_i) begin
            pre_d = (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) pre_q <= '0;
        else         pre_q <= pre_d;
    end

    assign tick_o = en_i && (pre_q == PRE_LAST);
endmodule

// File: rtl/lim_timer_rdmux.sv
module lim_timer_rdmux
    import lim_timer_pkg::*;
#(
    parameter int FRAC   = 9,
    parameter int UCNT_W = 53
) (
    input  logic              rd_en_i,
    input  logic [2:0]        idx_i,
    input  logic              user_i,
    input  logic              reached_i,
    input  logic              stop_i,
    input  logic [LIM_W-1:0]  lim_i,
    input  logic [UCNT_W-1:0] cnt_i,
    output logic [31:0]       rdata_o
);
    localparam int LOW_W = LIM_W - FRAC;

    logic [LIM_W-1:0] hi_word;
    logic [LOW_W-1:0] lo_bits;

    assign hi_word = LIM_W'(cnt_i >> LOW_W);
    assign lo_bits = cnt_i[LOW_W-1:0];

    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            case (idx_i)
                SLOT_LIM_RST: rdata_o = user_i ? {1'b0, hi_word} : {1'b0, lim_i};
                SLOT_COUNT:   rdata_o = {reached_i & ~user_i, lo_bits, {FRAC{1'b0}}};
                SLOT_RUN:     rdata_o = {31'd0, stop_i};
                SLOT_MODE:    rdata_o = {31'd0, user_i};
                default:      rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/lim_timer.sv
module lim_timer
    import lim_timer_pkg::*;
#(
    parameter int FRAC     = 9,
    parameter int UCNT_W   = 53,
    parameter int PRESCALE = 1,
    parameter bit MODE_WR  = 1'b1
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        tick_i,
    input  logic        sel_i,
    input  logic        wr_i,
    input  logic [2:0]  addr_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] rdata_o,
    output logic        irq_o
);
    localparam int CMP_W = ((UCNT_W > LIM_W) ? UCNT_W : LIM_W) + 1;

    typedef struct packed {
        logic [LIM_W-1:0]  lim;
        logic [UCNT_W-1:0] cnt;
        logic              reached;
        logic              irq;
        logic              stop;
        logic              user;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    logic             tick;
    logic             rd_go, wr_go, ack, advance, reach;
    logic [LIM_W-1:0] eff_lim, new_lim;
    logic [CMP_W-1:0] period, cnt_next;

    lim_timer_tick #(.PRESCALE(PRESCALE)) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (tick_i),
        .tick_o (tick)
    );

    always_comb begin
        rd_go    = sel_i && !wr_i;
        wr_go    = sel_i && wr_i;
        eff_lim  = (st_q.lim == '0) ? LIM_MAX : st_q.lim;
        period   = CMP_W'(eff_lim >> FRAC);
        cnt_next = CMP_W'(st_q.cnt) + 1'b1;
        new_lim  = (wdata_i == '0) ? LIM_MAX : wdata_i[LIM_W-1:0];
        advance  = tick && (!st_q.user || !st_q.stop);
        reach    = tick && !st_q.user && (cnt_next >= period);
        ack      = rd_go && (addr_i == SLOT_LIM_RST) && !st_q.user;

        st_d = st_q;
        if (advance) begin
            st_d.cnt = reach ? '0 : st_q.cnt + 1'b1;
        end
        if (ack) begin
            st_d.cnt     = '0;
            st_d.reached = 1'b0;
            st_d.irq     = 1'b0;
        end
        if (reach) begin
            st_d.reached = 1'b1;
            st_d.irq     = 1'b1;
        end
        if (wr_go) begin
            case (addr_i)
                SLOT_LIM_RST: begin
                    st_d.lim = new_lim;
                    st_d.cnt = '0;
                end
                SLOT_LIM_KEEP: st_d.lim = new_lim;
                SLOT_RUN: begin
                    if (st_q.user) st_d.stop = wdata_i[0];
                end
                SLOT_MODE: begin
                    if (MODE_WR) st_d.user = wdata_i[0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.lim     <= '0;
            st_q.cnt     <= '0;
            st_q.reached <= 1'b0;
            st_q.irq     <= 1'b0;
            st_q.stop    <= 1'b1;
            st_q.user    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    lim_timer_rdmux #(.FRAC(FRAC), .UCNT_W(UCNT_W)) u_rdmux (
        .rd_en_i   (rd_go),
        .idx_i     (addr_i),
        .user_i    (st_q.user),
        .reached_i (st_q.reached),
        .stop_i    (st_q.stop),
        .lim_i     (st_q.lim),
        .cnt_i     (st_q.cnt),
        .rdata_o   (rdata_o)
    );

    assign irq_o = st_q.irq && !st_q.user;
endmodule

// File: rtl/lim_timer_chk.sv
module lim_timer_chk #(
    parameter int FRAC   = 9,
    parameter int UCNT_W = 53
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              sel_i,
    input logic              wr_i,
    input logic [2:0]        addr_i,
    input logic [31:0]       rdata_o,
    input logic              irq_o,
    input logic              reach,
    input logic [UCNT_W-1:0] cnt_q,
    input logic              user_q,
    input logic              stop_q,
    input logic              irq_q
);
    logic rd0;
    assign rd0 = sel_i && !wr_i && (addr_i == 3'd0);

    p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reach |=> (cnt_q == '0));

    p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_q && !(rd0 && !user_q)) |=> irq_q);

    p_ack_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd0 && !user_q && !reach) |=> !irq_o);

    p_ack_race_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd0 && reach) |=> irq_o);

    p_user_noset_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (user_q && !irq_q) |=> !irq_q);

    p_sys_run_lock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && wr_i && addr_i == 3'd3 && !user_q) |=> $stable(stop_q));

    p_low_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && !wr_i && addr_i == 3'd1) |-> (rdata_o[FRAC-1:0] == '0));
endmodule

bind lim_timer lim_timer_chk #(.FRAC(FRAC), .UCNT_W(UCNT_W)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o),
    .reach   (reach),
    .cnt_q   (st_q.cnt),
    .user_q  (st_q.user),
    .stop_q  (st_q.stop),
    .irq_q   (st_q.irq)
);

// File: tb/tb_lim_timer.sv
`timescale 1ns/1ps
module tb_lim_timer;
    localparam int B_FRAC = 26;
    localparam int B_LOW  = 31 - B_FRAC;
    localparam int B_UCNT = 12;
    localparam int unsigned LOWMASK = (1 << B_LOW) - 1;
    localparam int unsigned CNTMASK = (1 << B_UCNT) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        tick = 1'b0, sel = 1'b0, wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    logic        p_tick = 1'b0, p_sel = 1'b0, p_wr = 1'b0;
    logic [2:0]  p_addr = '0;
    logic [31:0] p_wdata = '0;
    logic [31:0] p_rdata;
    logic        p_irq;

    lim_timer #(.FRAC(B_FRAC), .UCNT_W(B_UCNT), .PRESCALE(1), .MODE_WR(1'b1)) dut (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sel_i(sel), .wr_i(wr),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

    lim_timer #(.FRAC(B_FRAC), .UCNT_W(B_UCNT), .PRESCALE(3), .MODE_WR(1'b0)) dut_pre (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(p_tick), .sel_i(p_sel), .wr_i(p_wr),
        .addr_i(p_addr), .wdata_i(p_wdata), .rdata_o(p_rdata), .irq_o(p_irq));

    int vecs = 0;
    int errs = 0;

    // bench model of the requirements
    int unsigned m_lim = 0, m_cnt = 0;
    bit m_re = 0, m_irq = 0, m_stop = 1, m_user = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int unsigned exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_user ? ((m_cnt >> B_LOW) & 32'h7FFF_FFFF) : m_lim;
            3'd1: return ((m_cnt & LOWMASK) << B_FRAC) |
                         ((!m_user && m_re) ? 32'h8000_0000 : 32'h0);
            3'd3: return {31'd0, m_stop};
            3'd4: return {31'd0, m_user};
            default: return 0;
        endcase
    endfunction

    function automatic string auto_tag(input logic [2:0] a);
        case (a)
            3'd0: return m_user ? "R7" : "R5";
            3'd1: return m_user ? "R7" : "R2";
            3'd3, 3'd4: return "R9";
            default: return "R1";
        endcase
    endfunction

    task automatic model_step(input bit s, input bit w, input logic [2:0] a,
                              input logic [31:0] d, input bit t);
        bit rd0, adv, rch;
        int unsigned eff, per, n_cnt, n_lim;
        bit n_re, n_irq, n_stop, n_user;
        rd0 = s && !w && a == 3'd0 && !m_user;
        eff = (m_lim == 0) ? 32'h7FFF_FFFF : m_lim;
        per = eff >> B_FRAC;
        adv = t && (!m_user || !m_stop);
        rch = t && !m_user && (m_cnt + 1 >= per);
        n_cnt = m_cnt; n_lim = m_lim; n_re = m_re; n_irq = m_irq;
        n_stop = m_stop; n_user = m_user;
        if (adv) n_cnt = rch ? 0 : ((m_cnt + 1) & CNTMASK);
        if (rd0) begin n_cnt = 0; n_re = 0; n_irq = 0; end
        if (rch) begin n_re = 1; n_irq = 1; end
        if (s && w) begin
            case (a)
                3'd0: begin n_lim = (d == 0) ? 32'h7FFF_FFFF : (d & 32'h7FFF_FFFF); n_cnt = 0; end
                3'd2: n_lim = (d == 0) ? 32'h7FFF_FFFF : (d & 32'h7FFF_FFFF);
                3'd3: if (m_user) n_stop = d[0];
                3'd4: n_user = d[0];
                default: ;
            endcase
        end
        m_cnt = n_cnt; m_lim = n_lim; m_re = n_re; m_irq = n_irq;
        m_stop = n_stop; m_user = n_user;
    endtask

    // one bus cycle; called just after a falling edge
    task automatic step(input bit s, input bit w, input logic [2:0] a,
                        input logic [31:0] d, input bit t, input string tag);
        string tg;
        sel = s; wr = w; addr = a; wdata = d; tick = t;
        #1;
        chk("R4 irq", {31'd0, irq}, {31'd0, m_irq && !m_user});
        if (s && !w) begin
            tg = (tag == "") ? auto_tag(a) : tag;
            chk(tg, rdata, exp_rd(a));
        end
        model_step(s, w, a, d, t);
        @(posedge clk);
        @(negedge clk);
        sel = 0; wr = 0; tick = 0;
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        step(1, 0, a, 0, 0, tag);
    endtask
    task automatic wrr(input logic [2:0] a, input logic [31:0] d);
        step(1, 1, a, d, 0, "");
    endtask
    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1, "");
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        #1;
        chk("R10 irq", {31'd0, irq}, 32'd0);
        rd(3'd3, "R10");
        rd(3'd4, "R10");
        rd(3'd1, "R10");
        rd(3'd0, "R10");

        // R11: prescaled tick source, 21 enabled cycles /3 -> 7 ticks
        p_tick = 1'b1;
        repeat (21) @(posedge clk);
        @(negedge clk);
        p_tick = 1'b0; p_sel = 1'b1; p_wr = 1'b0; p_addr = 3'd1;
        #1;
        chk("R11", p_rdata, 32'd7 << B_FRAC);
        chk("R11 irq", {31'd0, p_irq}, 32'd0);
        @(negedge clk);
        // R9: mode write ignored when not writable
        p_wr = 1'b1; p_addr = 3'd4; p_wdata = 32'd1;
        @(negedge clk);
        p_wr = 1'b0;
        #1;
        chk("R9 locked mode", p_rdata, 32'd0);
        @(negedge clk);
        p_sel = 1'b0;

        // R3: limit writes
        wrr(3'd0, 32'd5 << B_FRAC);
        ticks(3);
        rd(3'd1, "R3");
        wrr(3'd2, 32'd20 << B_FRAC);
        rd(3'd1, "R3 keep count");
        rd(3'd0, "R3 limit");
        wrr(3'd2, 32'd0);
        rd(3'd0, "R3 zero->max");

        // R4 / R5: wrap and acknowledge
        wrr(3'd0, 32'd3 << B_FRAC);
        ticks(3);
        #0 chk("R4 irq set", {31'd0, irq}, 32'd1);
        rd(3'd1, "R4");
        ticks(2);
        rd(3'd1, "R4 sticky");
        rd(3'd0, "R5");
        #0 chk("R5 irq clr", {31'd0, irq}, 32'd0);
        rd(3'd1, "R5");

        // R6: wrap collides with acknowledging read
        wrr(3'd0, 32'd2 << B_FRAC);
        ticks(1);
        step(1, 0, 3'd0, 0, 1, "R6");
        #0 chk("R6 irq kept", {31'd0, irq}, 32'd1);
        rd(3'd1, "R6");

        // R1: unused slots
        wrr(3'd6, 32'hFFFF_FFFF);
        rd(3'd5, "R1");
        rd(3'd6, "R1");
        rd(3'd7, "R1");
        rd(3'd0, "R1");

        // R8: system mode ignores run control
        wrr(3'd3, 32'd0);
        rd(3'd3, "R8 sys ignore");

        // R7 / R8: user mode
        wrr(3'd4, 32'd1);
        rd(3'd4, "R9");
        ticks(4);
        rd(3'd1, "R8 stopped");
        wrr(3'd3, 32'd0);
        ticks(40);
        rd(3'd0, "R7 hi");
        rd(3'd1, "R7 lo");
        #0 chk("R7 irq", {31'd0, irq}, 32'd0);
        wrr(3'd3, 32'd1);
        ticks(6);
        rd(3'd1, "R8 held");
        wrr(3'd3, 32'd0);
        ticks(2);
        rd(3'd1, "R8 resumed");
        wrr(3'd4, 32'd0);

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            int unsigned op;
            logic [31:0] d;
            bit t;
            op = $urandom % 16;
            t = ($urandom % 3) != 0;
            d = (($urandom % 7) << B_FRAC) | ($urandom & 32'h03FF_FFFF);
            if (($urandom % 20) == 0) d = 32'd0;
            if (($urandom % 20) == 0) d = 32'h8000_0000;
            if (op < 5)        step(0, 0, 0, 0, t, "");
            else if (op < 11)  step(1, 0, 3'($urandom % 8), 0, t, "");
            else if (op < 13)  step(1, 1, ($urandom % 2) ? 3'd0 : 3'd2, d, t, "");
            else if (op < 14)  step(1, 1, 3'd3, {31'd0, 1'($urandom % 2)}, t, "");
            else if (op < 15)  step(1, 1, 3'd4, {31'd0, 1'(($urandom % 4) == 0)}, t, "");
            else               step(1, 1, 3'($urandom % 8), $urandom, t, "");
        end

        summary();
        $finish;
    end
endmodule